// File: doc/BRIEF.md
# Receive Buffer-Ready Interrupt Scheduler

This block decides, for one receive pipe, the cycle in which the buffer-ready interrupt status is raised. A packet engine reports each received packet with a one-cycle strobe. The strobe carries the byte length and a zero-length flag. The engine also reports whether the packet ended the transaction counter. The reader that empties the buffer reports completion with a one-cycle drained strobe. Software reads a sticky status bit and clears it by writing one. Software also reads the length of the most recent packet.

Two modes are selected by one mode bit.

- **Immediate mode (bit clear):** every packet raises the status.
- **End-of-transfer mode (bit set):** the raising depends on the packet.
  - Full-size packets are silent.
  - A zero-length packet raises the status at once.
  - A short packet, or a packet that ends the transaction counter, arms a pending flag. The pending flag raises the status when the buffer has been drained.

The end-of-transfer mode only acts on receive pipes. When the direction bit marks a transmit pipe, the block behaves as in immediate mode.

Top module: `rx_ready_sched`

## Requirements
- R1: After a synchronous active-high reset, `irqStatus` is 0, `lastLen` is 0 and nothing is pending: a drained strobe that follows raises nothing.
- R2: With `deferMode` = 0, any packet strobe sets `irqStatus` on the next clock edge, whatever the length or `tcEnd`.
- R3: With `deferMode` = 1 and `dirTx` = 0, a packet with `pktZero` = 0, `tcEnd` = 0 and `pktLen` >= `maxPkt` leaves `irqStatus` unchanged, and a later drained strobe also leaves it unchanged.
- R4: With `deferMode` = 1 and `dirTx` = 0, a packet with `pktZero` = 1 sets `irqStatus` on the next edge, even when `tcEnd` = 1.
- R5: With `deferMode` = 1 and `dirTx` = 0, a non-zero packet with `pktLen` < `maxPkt` does not set `irqStatus`. The next `drainDone` strobe sets `irqStatus` on the following edge.
- R6: With `deferMode` = 1 and `dirTx` = 0, a non-zero packet with `tcEnd` = 1 is deferred in the same way as in R5, even when it is full-size.
- R7: With `dirTx` = 1, the block behaves as with `deferMode` = 0.
- R8: `irqStatus` stays set until `irqClrWr` = 1 clears it at the next edge. An event that sets it in the same cycle as the clear wins, and the bit stays set.
- R9: Every packet strobe loads `lastLen` on the next edge. The loaded value is `pktLen`, or 0 when `pktZero` = 1.
- R10: A `drainDone` strobe with nothing pending has no effect on `irqStatus`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pktValid | input | 1 | One-cycle strobe: a packet was received |
| pktLen | input | LEN_W | Byte length of the received packet |
| pktZero | input | 1 | Received packet has zero length |
| tcEnd | input | 1 | Received packet ended the transaction counter |
| maxPkt | input | LEN_W | Configured maximum packet size |
| drainDone | input | 1 | One-cycle strobe: the reader finished draining the buffer |
| deferMode | input | 1 | 1 selects end-of-transfer mode |
| dirTx | input | 1 | 1 marks the pipe as transmit |
| irqClrWr | input | 1 | Software write of one to the status bit |
| irqStatus | output | 1 | Sticky buffer-ready interrupt status |
| lastLen | output | LEN_W | Length of the most recent packet |

## Verification
The pending flag cannot be seen at the ports. Its state is shown only by whether a later drained strobe raises the status. For this reason, every swept packet is followed by a clear, a check, a drained strobe and a second check.

The hardest case is a drained strobe that meets a new deferring packet in the same cycle. That drain raises the status, and the new packet must leave the flag armed. A directed sequence creates this collision and then drains a second time to show that the flag was re-armed.

// File: rtl/rx_ready_sched_pkg.sv
package rx_ready_sched_pkg;

  typedef enum logic [1:0] {
    CLS_ZERO,
    CLS_FULL,
    CLS_DEFER
  } pktClass_t;

  typedef struct packed {
    logic setIrq;
    logic clrIrq;
    logic setPend;
    logic clrPend;
    logic loadLen;
    logic lenZero;
  } schedStrobe_t;

endpackage

// File: rtl/rx_ready_sched_ctrl.sv
module rx_ready_sched_ctrl
  import rx_ready_sched_pkg::*;
#(
  parameter int LEN_W = 11
) (
  input  logic             pktValid,
  input  logic [LEN_W-1:0] pktLen,
  input  logic             pktZero,
  input  logic             tcEnd,
  input  logic [LEN_W-1:0] maxPkt,
  input  logic             drainDone,
  input  logic             deferMode,
  input  logic             dirTx,
  input  logic             irqClrWr,
  input  logic             pendQ,
  output schedStrobe_t     strb
);

  logic      deferActive;
  pktClass_t pktClass;
  logic      drainFires;

  assign deferActive = deferMode & ~dirTx;
  assign drainFires  = drainDone & pendQ;

  // Zero length has priority over counter end; counter end over size.
  always_comb begin
    if (pktZero)              pktClass = CLS_ZERO;
    else if (tcEnd)           pktClass = CLS_DEFER;
    else if (pktLen >= maxPkt) pktClass = CLS_FULL;
    else                      pktClass = CLS_DEFER;
  end

  always_comb begin
    strb         = '0;
    strb.clrIrq  = irqClrWr;
    strb.loadLen = pktValid;
    strb.lenZero = pktZero;
    strb.clrPend = drainFires;
    strb.setIrq  = drainFires;
    if (pktValid) begin
      if (!deferActive) begin
        strb.setIrq = 1'b1;
      end else begin
        unique case (pktClass)
          CLS_ZERO:  strb.setIrq  = 1'b1;
          CLS_DEFER: strb.setPend = 1'b1;
          default:   ;
        endcase
      end
    end
  end

endmodule

// File: rtl/rx_ready_sched_dp.sv
module rx_ready_sched_dp
  import rx_ready_sched_pkg::*;
#(
  parameter int LEN_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  schedStrobe_t     strb,
  input  logic [LEN_W-1:0] pktLen,
  output logic             pendQ,
  output logic             irqQ,
  output logic [LEN_W-1:0] lenQ
);

  always_ff @(posedge clk) begin
    if (rst) begin
      pendQ <= 1'b0;
      irqQ  <= 1'b0;
      lenQ  <= '0;
    end else begin
      // A new arming wins over a drain in the same cycle.
      if (strb.setPend)      pendQ <= 1'b1;
      else if (strb.clrPend) pendQ <= 1'b0;

      // A set wins over a software clear in the same cycle.
      if (strb.setIrq)      irqQ <= 1'b1;
      else if (strb.clrIrq) irqQ <= 1'b0;

      if (strb.loadLen) lenQ <= strb.lenZero ? '0 : pktLen;
    end
  end

endmodule

// File: rtl/rx_ready_sched.sv
module rx_ready_sched
  import rx_ready_sched_pkg::*;
#(
  parameter int LEN_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pktValid,
  input  logic [LEN_W-1:0] pktLen,
  input  logic             pktZero,
  input  logic             tcEnd,
  input  logic [LEN_W-1:0] maxPkt,
  input  logic             drainDone,
  input  logic             deferMode,
  input  logic             dirTx,
  input  logic             irqClrWr,
  output logic             irqStatus,
  output logic [LEN_W-1:0] lastLen
);

  schedStrobe_t strb;
  logic         pendQ;

  rx_ready_sched_ctrl #(.LEN_W(LEN_W)) uCtrl (
    .pktValid (pktValid),
    .pktLen   (pktLen),
    .pktZero  (pktZero),
    .tcEnd    (tcEnd),
    .maxPkt   (maxPkt),
    .drainDone(drainDone),
    .deferMode(deferMode),
    .dirTx    (dirTx),
    .irqClrWr (irqClrWr),
    .pendQ    (pendQ),
    .strb     (strb)
  );

  rx_ready_sched_dp #(.LEN_W(LEN_W)) uDp (
    .clk   (clk),
    .rst   (rst),
    .strb  (strb),
    .pktLen(pktLen),
    .pendQ (pendQ),
    .irqQ  (irqStatus),
    .lenQ  (lastLen)
  );

endmodule

// File: rtl/rx_ready_sched_chk.sv
module rx_ready_sched_chk #(
  parameter int LEN_W = 11
) (
  input logic             clk,
  input logic             rst,
  input logic             pktValid,
  input logic [LEN_W-1:0] pktLen,
  input logic             pktZero,
  input logic             tcEnd,
  input logic [LEN_W-1:0] maxPkt,
  input logic             drainDone,
  input logic             deferMode,
  input logic             dirTx,
  input logic             irqClrWr,
  input logic             irqStatus,
  input logic [LEN_W-1:0] lastLen
);

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!irqStatus && lastLen == '0)); // R1

  AST_IMMEDIATE_MODE: assert property (@(posedge clk) disable iff (rst)
    (pktValid && (!deferMode || dirTx)) |=> irqStatus); // R2

  AST_FULL_SILENT: assert property (@(posedge clk) disable iff (rst)
    (pktValid && deferMode && !dirTx && !pktZero && !tcEnd && pktLen >= maxPkt
     && !irqStatus && !drainDone) |=> !irqStatus); // R3

  AST_ZERO_IMMEDIATE: assert property (@(posedge clk) disable iff (rst)
    (pktValid && pktZero) |=> irqStatus); // R4

  AST_STICKY: assert property (@(posedge clk) disable iff (rst)
    (irqStatus && !irqClrWr) |=> irqStatus); // R8

  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (rst)
    (irqClrWr && !pktValid && !drainDone) |=> !irqStatus); // R8

  AST_LEN_LOAD: assert property (@(posedge clk) disable iff (rst)
    pktValid |=> (lastLen == ($past(pktZero) ? '0 : $past(pktLen)))); // R9

  AST_LEN_HOLD: assert property (@(posedge clk) disable iff (rst)
    !pktValid |=> $stable(lastLen)); // R9

endmodule

bind rx_ready_sched rx_ready_sched_chk #(.LEN_W(LEN_W)) uChk (.*);

// File: tb/tb_rx_ready_sched.sv
`timescale 1ns/1ps
module tb_rx_ready_sched;

  localparam int LEN_W = 4;

  logic             clk = 1'b0;
  logic             rst;
  logic             pktValid;
  logic [LEN_W-1:0] pktLen;
  logic             pktZero;
  logic             tcEnd;
  logic [LEN_W-1:0] maxPkt;
  logic             drainDone;
  logic             deferMode;
  logic             dirTx;
  logic             irqClrWr;
  logic             irqStatus;
  logic [LEN_W-1:0] lastLen;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #4 clk = ~clk;  // 125 MHz

  rx_ready_sched #(.LEN_W(LEN_W)) dut (.*);

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run did not finish (actual %0d cycles, expected fewer)", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // Inputs change 1 ns after a rising edge; outputs are sampled there too.
  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    pktValid  = 1'b0;
    pktLen    = '0;
    pktZero   = 1'b0;
    tcEnd     = 1'b0;
    drainDone = 1'b0;
    irqClrWr  = 1'b0;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic sendPkt(input int len, input logic tc);
    pktValid = 1'b1;
    pktLen   = LEN_W'(len);
    pktZero  = (len == 0);
    tcEnd    = tc;
    tick();
    idle();
  endtask

  task automatic drain();
    drainDone = 1'b1;
    tick();
    idle();
  endtask

  task automatic clearIrq();
    irqClrWr = 1'b1;
    tick();
    idle();
  endtask

  initial begin
    rst       = 1'b1;
    deferMode = 1'b0;
    dirTx     = 1'b0;
    maxPkt    = 4'd8;
    idle();
    tick();
    tick();
    rst = 1'b0;

    // R1: reset state, and no pending flag after reset.
    chk("R1 irqStatus", int'(irqStatus), 0);
    chk("R1 lastLen", int'(lastLen), 0);
    deferMode = 1'b1;
    drain();
    chk("R1 no pending after reset", int'(irqStatus), 0);

    // Sweep over mode, direction, max size, length and counter end.
    for (int m = 0; m < 2; m++) begin
      for (int d = 0; d < 2; d++) begin
        for (int mx = 0; mx < 2; mx++) begin
          for (int len = 0; len < 16; len++) begin
            for (int tc = 0; tc < 2; tc++) begin
              bit act;
              bit imm;
              bit dly;
              deferMode = m[0];
              dirTx     = d[0];
              maxPkt    = (mx == 0) ? 4'd8 : 4'd15;
              act = m[0] && !d[0];
              imm = 1'b0;
              dly = 1'b0;
              if (!act)                                imm = 1'b1;
              else if (len == 0)                       imm = 1'b1;
              else if (tc == 1)                        dly = 1'b1;
              else if (len < int'(maxPkt))             dly = 1'b1;
              clearIrq();
              chk("R8 clear", int'(irqStatus), 0);
              sendPkt(len, tc[0]);
              if (!act)
                chk(d[0] ? "R7 tx pipe immediate" : "R2 immediate mode", int'(irqStatus), 1);
              else if (len == 0)
                chk("R4 zero immediate", int'(irqStatus), 1);
              else if (tc == 1)
                chk("R6 counter end held", int'(irqStatus), 0);
              else if (dly)
                chk("R5 short held", int'(irqStatus), 0);
              else
                chk("R3 full silent", int'(irqStatus), 0);
              chk("R9 lastLen", int'(lastLen), len);
              tick();
              chk("R8 sticky", int'(irqStatus), int'(imm));
              drain();
              if (act && tc == 1 && len != 0)
                chk("R6 raised after drain", int'(irqStatus), 1);
              else if (dly)
                chk("R5 raised after drain", int'(irqStatus), 1);
              else if (act && len != 0)
                chk("R3 drain after full", int'(irqStatus), 0);
              else
                chk("R10 drain without pending", int'(irqStatus), int'(imm));
            end
          end
        end
      end
    end

    // R8: a set in the same cycle as a clear wins.
    deferMode = 1'b0;
    dirTx     = 1'b0;
    maxPkt    = 4'd8;
    clearIrq();
    pktValid = 1'b1;
    pktLen   = 4'd3;
    irqClrWr = 1'b1;
    tick();
    idle();
    chk("R8 set wins over clear", int'(irqStatus), 1);

    // R5: a drain meeting a new short packet raises the status and re-arms.
    deferMode = 1'b1;
    clearIrq();
    sendPkt(2, 1'b0);
    drainDone = 1'b1;
    pktValid  = 1'b1;
    pktLen    = 4'd5;
    tick();
    idle();
    chk("R5 drain raises during new packet", int'(irqStatus), 1);
    chk("R9 lastLen new packet", int'(lastLen), 5);
    clearIrq();
    chk("R8 clear after collision", int'(irqStatus), 0);
    drain();
    chk("R5 re-armed flag raises", int'(irqStatus), 1);
    clearIrq();
    drain();
    chk("R10 second drain no effect", int'(irqStatus), 0);

    // R1: reset in mid-use drops a pending flag.
    sendPkt(4, 1'b0);
    rst = 1'b1;
    tick();
    rst = 1'b0;
    chk("R1 lastLen after reset", int'(lastLen), 0);
    drain();
    chk("R1 pending dropped by reset", int'(irqStatus), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule